// File: doc/BRIEF.md
# In-situ storage pixel sensor sequencer

This block produces the digital timing for an image sensor whose pixels each hold a short serial charge store. When a bunch train begins, a one-cycle train strobe starts a capture phase. The photogate stays enabled for the whole phase. At the end of every capture interval a global transfer pulse moves the collected charge into the per-pixel store. This repeats until the store has received `DEPTH` samples. During this phase no store clocking and no row selection take place.

In the quiet period after the train, the block reads the array one row at a time. The selected row's line stays high while all of its stored samples are converted in parallel across the columns. Each sample takes two readout ticks so that downstream logic can do correlated double sampling:

- In the first tick the reset gate pulses, and the reset level is marked valid on the tick's last cycle.
- In the second tick the store advances one position on two non-overlapping clock phases, and the signal level is marked valid on the tick's last cycle.

Row and sample indices travel with the valid strobe. A one-cycle done pulse follows the last sample, and the block then waits for the next train. A strobe that arrives during readout is dropped and sets a sticky overrun flag.

All rates come from the system clock through parameterised dividers. The defaults assume a 100 MHz clock, 20 kHz captures (`CAP_DIV` = 5000), 1 MHz readout ticks (`RD_DIV` = 100), 20 samples per pixel and 16 rows.

Top module: `isstore_seq`

## Requirements
- R1: While reset is asserted and after it is released with no train strobe, every output is 0, including `overrun`.
- R2: A `train_start` high in idle starts capture in the next cycle. `pg_en` is then high for exactly `DEPTH*CAP_DIV` consecutive cycles.
- R3: During capture, `xfer` is high for one cycle, on the last cycle of each `CAP_DIV`-cycle interval, giving exactly `DEPTH` pulses per train.
- R4: During capture, `stor_ph1`, `stor_ph2`, `rst_gate`, `row_sel` and `smp_vld` stay 0.
- R5: Readout begins in the cycle after the last transfer. Rows are read in ascending order. For row r, `row_sel` is one-hot with bit r set for `2*DEPTH*RD_DIV` cycles. `row_sel` is 0 outside readout.
- R6: A readout tick lasts `RD_DIV` cycles. Ticks alternate between reset and signal, starting with reset. In a reset tick, `rst_gate` is high for cycles 0 to `RD_DIV/4`-1 and `smp_sig` is 0. In a signal tick, `smp_sig` is 1, `stor_ph1` is high for cycles 0 to `RD_DIV/2`-1, and `stor_ph2` is high from cycle `RD_DIV/2` through cycle `RD_DIV`-2. `smp_vld` is high only on cycle `RD_DIV`-1 of every tick.
- R7: During readout, `smp_row` and `smp_idx` give the current row and sample. Samples run from 0 to `DEPTH`-1 within each row. Both are 0 outside readout.
- R8: `done` is high for exactly one cycle, the cycle after the last signal-level valid of the last row. The block is then idle and a new strobe is accepted.
- R9: A `train_start` during readout leaves every sequencing output unchanged. It sets `overrun` from the next cycle, and `overrun` then stays 1 until reset.
- R10: A `train_start` during capture, including its last cycle, has no effect on any output and does not set `overrun`.
- R11: Asserting `rst_n` mid-sequence clears all outputs at once, without waiting for a clock edge. After release, a new train runs from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| train_start | input | 1 | One-cycle strobe marking the start of a bunch train |
| pg_en | output | 1 | Photogate enable, high for the whole capture phase |
| xfer | output | 1 | Global transfer pulse from photogate into the pixel store |
| stor_ph1 | output | 1 | Store clock, first phase |
| stor_ph2 | output | 1 | Store clock, second phase |
| rst_gate | output | 1 | Global output-node reset pulse |
| row_sel | output | ROWS | One-hot row select during readout |
| smp_vld | output | 1 | Column converters sample on this cycle |
| smp_sig | output | 1 | 0 = reset level, 1 = signal level |
| smp_row | output | RW = clog2(ROWS) | Row index of the current sample |
| smp_idx | output | SW = clog2(DEPTH) | Storage-sample index of the current sample |
| done | output | 1 | One-cycle pulse after the final sample |
| overrun | output | 1 | Sticky flag: train strobe seen during readout |

## Verification
Every port is compared on every cycle of whole trains against positions computed from the cycle count since the strobe. Each output is decoded directly from the phase and counter state, so a miscounted divider, sample index or row index shows up on the ports in the same cycle, as a shifted `xfer`, `smp_vld` or `row_sel` edge. A phase register that leaves capture early or late shifts the start of readout, and every later comparison in that train fails. Strobes placed on the last capture cycle and on the first readout cycle probe the edges of the overrun rule.

// File: rtl/isstore_pkg.sv
package isstore_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAP  = 2'd1,
    PH_RD   = 2'd2
  } phase_t;

  // index width for a counter that takes n distinct values
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/isstore_tick.sv
module isstore_tick #(
  parameter  int unsigned DIV = 100,
  localparam int unsigned CW  = isstore_pkg::idx_w(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_d;

  // held at zero while disabled, so a phase always starts at count 0
  always_comb begin
    cnt_d = cnt;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R6

  AST_TICK_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0); // R6

endmodule

// File: rtl/isstore_idx.sv
module isstore_idx #(
  parameter  int unsigned LIMIT = 20,
  localparam int unsigned IW    = isstore_pkg::idx_w(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  output logic [IW-1:0] idx
);

  localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);

  logic [IW-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (!en) begin
      idx_d = '0;
    end else if (step) begin
      if (idx == LAST) begin
        idx_d = '0;
      end else begin
        idx_d = idx + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else begin
      idx <= idx_d;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST); // R7

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> (idx == $past(idx) || !en)); // R7

endmodule

// File: rtl/isstore_seq.sv
module isstore_seq #(
  parameter  int unsigned CAP_DIV = 5000,
  parameter  int unsigned RD_DIV  = 100,
  parameter  int unsigned DEPTH   = 20,
  parameter  int unsigned ROWS    = 16,
  localparam int unsigned RW      = isstore_pkg::idx_w(ROWS),
  localparam int unsigned SW      = isstore_pkg::idx_w(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            train_start,
  output logic            pg_en,
  output logic            xfer,
  output logic            stor_ph1,
  output logic            stor_ph2,
  output logic            rst_gate,
  output logic [ROWS-1:0] row_sel,
  output logic            smp_vld,
  output logic            smp_sig,
  output logic [RW-1:0]   smp_row,
  output logic [SW-1:0]   smp_idx,
  output logic            done,
  output logic            overrun
);

  import isstore_pkg::*;

  localparam int unsigned CCW = idx_w(CAP_DIV);
  localparam int unsigned RCW = idx_w(RD_DIV);

  localparam logic [CCW-1:0] CAP_LAST  = CCW'(CAP_DIV - 1);
  localparam logic [RCW-1:0] RD_LAST   = RCW'(RD_DIV - 1);
  localparam logic [RCW-1:0] RD_HALF   = RCW'(RD_DIV / 2);
  localparam logic [RCW-1:0] RD_QTR    = RCW'(RD_DIV / 4);
  localparam logic [SW-1:0]  SMP_LAST  = SW'(DEPTH - 1);
  localparam logic [RW-1:0]  ROW_LAST  = RW'(ROWS - 1);

  // ---------------------------------------------------------------
  // reset: asserted asynchronously, released on the clock
  // ---------------------------------------------------------------
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_sn = rsync_q[1];

  // ---------------------------------------------------------------
  // phase register and flags
  // ---------------------------------------------------------------
  phase_t st_q, st_d;
  logic   done_q, done_d;
  logic   ovr_q, ovr_d;

  logic in_cap, in_rd;
  assign in_cap = (st_q == PH_CAP);
  assign in_rd  = (st_q == PH_RD);

  // ---------------------------------------------------------------
  // dividers and index counters
  // ---------------------------------------------------------------
  logic [CCW-1:0] cap_cnt;
  logic [RCW-1:0] rd_cnt;
  logic [SW-1:0]  cap_idx;
  logic           lvl;
  logic [SW-1:0]  smp_q;
  logic [RW-1:0]  row_q;

  logic cap_wrap, cap_last, rd_wrap, smp_last, row_last;

  isstore_tick #(.DIV(CAP_DIV)) u_cap_tick (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (in_cap),
    .cnt   (cap_cnt)
  );

  isstore_tick #(.DIV(RD_DIV)) u_rd_tick (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (in_rd),
    .cnt   (rd_cnt)
  );

  assign cap_wrap = in_cap && (cap_cnt == CAP_LAST);
  assign rd_wrap  = in_rd  && (rd_cnt  == RD_LAST);

  isstore_idx #(.LIMIT(DEPTH)) u_cap_idx (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (in_cap),
    .step  (cap_wrap),
    .idx   (cap_idx)
  );

  // level: 0 = reset tick, 1 = signal tick
  isstore_idx #(.LIMIT(2)) u_lvl (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (in_rd),
    .step  (rd_wrap),
    .idx   (lvl)
  );

  isstore_idx #(.LIMIT(DEPTH)) u_smp (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (in_rd),
    .step  (rd_wrap && lvl),
    .idx   (smp_q)
  );

  assign smp_last = (smp_q == SMP_LAST);

  isstore_idx #(.LIMIT(ROWS)) u_row (
    .clk   (clk),
    .rst_n (rst_sn),
    .en    (in_rd),
    .step  (rd_wrap && lvl && smp_last),
    .idx   (row_q)
  );

  assign cap_last = (cap_idx == SMP_LAST);
  assign row_last = (row_q == ROW_LAST);

  // ---------------------------------------------------------------
  // next-state logic
  // ---------------------------------------------------------------
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    ovr_d  = ovr_q;
    case (st_q)
      PH_IDLE: begin
        if (train_start) begin
          st_d = PH_CAP;
        end
      end
      PH_CAP: begin
        if (cap_wrap && cap_last) begin
          st_d = PH_RD;
        end
      end
      PH_RD: begin
        if (train_start) begin
          ovr_d = 1'b1;
        end
        if (rd_wrap && lvl && smp_last && row_last) begin
          st_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: begin
        st_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= PH_IDLE;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

  // ---------------------------------------------------------------
  // output decode
  // ---------------------------------------------------------------
  assign pg_en    = in_cap;
  assign xfer     = cap_wrap;
  assign rst_gate = in_rd && !lvl && (rd_cnt < RD_QTR);
  assign stor_ph1 = in_rd && lvl && (rd_cnt < RD_HALF);
  assign stor_ph2 = in_rd && lvl && (rd_cnt >= RD_HALF) && (rd_cnt != RD_LAST);
  assign smp_vld  = rd_wrap;
  assign smp_sig  = in_rd && lvl;
  assign smp_row  = row_q;
  assign smp_idx  = smp_q;
  assign done     = done_q;
  assign overrun  = ovr_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = in_rd && (row_q == RW'(r));
  end

  // ---------------------------------------------------------------
  // checks
  // ---------------------------------------------------------------
  AST_QUIET_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sn)
    pg_en |-> (!stor_ph1 && !stor_ph2 && !rst_gate && row_sel == '0 && !smp_vld)); // R4

  AST_XFER_WITH_PG: assert property (@(posedge clk) disable iff (!rst_sn)
    xfer |-> pg_en); // R3

  AST_ROWSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(row_sel)); // R5

  AST_PHASES_APART: assert property (@(posedge clk) disable iff (!rst_sn)
    !(stor_ph1 && stor_ph2)); // R6

  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    smp_vld |-> (!stor_ph1 && !stor_ph2 && !rst_gate)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> (!pg_en && row_sel == '0)); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    overrun |=> overrun); // R9

  AST_NO_OVR_FROM_CAP: assert property (@(posedge clk) disable iff (!rst_sn)
    (pg_en && !overrun) |=> !overrun); // R10

endmodule

// File: tb/isstore_seq_tb.sv
`timescale 1ns/1ps
module isstore_seq_tb;

  localparam int CAP_DIV = 7;
  localparam int RD_DIV  = 8;
  localparam int DEPTH   = 5;
  localparam int ROWS    = 4;
  localparam int RW      = $clog2(ROWS);
  localparam int SW      = $clog2(DEPTH);
  localparam int CAPT    = DEPTH * CAP_DIV;
  localparam int RDT     = ROWS * DEPTH * 2 * RD_DIV;
  localparam int TOTAL   = CAPT + RDT;

  logic            clk;
  logic            rst_n;
  logic            train_start;
  logic            pg_en, xfer, stor_ph1, stor_ph2, rst_gate;
  logic [ROWS-1:0] row_sel;
  logic            smp_vld, smp_sig;
  logic [RW-1:0]   smp_row;
  logic [SW-1:0]   smp_idx;
  logic            done, overrun;

  int n_chk = 0;
  int n_bad = 0;

  isstore_seq #(
    .CAP_DIV (CAP_DIV),
    .RD_DIV  (RD_DIV),
    .DEPTH   (DEPTH),
    .ROWS    (ROWS)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .train_start (train_start),
    .pg_en       (pg_en),
    .xfer        (xfer),
    .stor_ph1    (stor_ph1),
    .stor_ph2    (stor_ph2),
    .rst_gate    (rst_gate),
    .row_sel     (row_sel),
    .smp_vld     (smp_vld),
    .smp_sig     (smp_sig),
    .smp_row     (smp_row),
    .smp_idx     (smp_idx),
    .done        (done),
    .overrun     (overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all_zero(input string tag);
    chk(tag, int'({pg_en, xfer, stor_ph1, stor_ph2, rst_gate, smp_vld, smp_sig}), 0);
    chk(tag, int'(row_sel), 0);
    chk(tag, int'(smp_row), 0);
    chk(tag, int'(smp_idx), 0);
    chk(tag, int'(done), 0);
    chk(tag, int'(overrun), 0);
  endtask

  // t = cycles since the accepted strobe edge; t < 0 means plain idle
  task automatic check_cycle(input int t, input int ovr_e);
    int e_pg = 0, e_xf = 0, e_p1 = 0, e_p2 = 0, e_rg = 0;
    int e_rs = 0, e_vl = 0, e_sg = 0, e_row = 0, e_idx = 0, e_dn = 0;
    if (t >= 0 && t < CAPT) begin
      e_pg = 1;
      e_xf = ((t % CAP_DIV) == CAP_DIV - 1) ? 1 : 0;
      chk("R4 store/row/valid quiet in capture",
          int'({stor_ph1, stor_ph2, rst_gate, smp_vld}) + int'(row_sel), 0);
    end else if (t >= CAPT && t < TOTAL) begin
      int u, tk, c, lv;
      u     = t - CAPT;
      tk    = u / RD_DIV;
      c     = u % RD_DIV;
      lv    = tk % 2;
      e_idx = (tk / 2) % DEPTH;
      e_row = tk / (2 * DEPTH);
      e_rs  = 1 << e_row;
      e_rg  = (lv == 0 && c < RD_DIV / 4) ? 1 : 0;
      e_p1  = (lv == 1 && c < RD_DIV / 2) ? 1 : 0;
      e_p2  = (lv == 1 && c >= RD_DIV / 2 && c < RD_DIV - 1) ? 1 : 0;
      e_vl  = (c == RD_DIV - 1) ? 1 : 0;
      e_sg  = lv;
    end else if (t == TOTAL) begin
      e_dn = 1;
    end
    chk("R2 pg_en", int'(pg_en), e_pg);
    chk("R3 xfer", int'(xfer), e_xf);
    chk("R5 row_sel", int'(row_sel), e_rs);
    chk("R6 rst_gate", int'(rst_gate), e_rg);
    chk("R6 stor_ph1", int'(stor_ph1), e_p1);
    chk("R6 stor_ph2", int'(stor_ph2), e_p2);
    chk("R6 smp_vld", int'(smp_vld), e_vl);
    chk("R6 smp_sig", int'(smp_sig), e_sg);
    chk("R7 smp_row", int'(smp_row), e_row);
    chk("R7 smp_idx", int'(smp_idx), e_idx);
    chk("R8 done", int'(done), e_dn);
    chk("R9/R10 overrun", int'(overrun), ovr_e);
  endtask

  // runs a full train; inj_t >= 0 places an extra strobe at that cycle
  task automatic run_train(input int inj_t, inout int ovr_e);
    @(negedge clk);
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
    for (int t = 0; t <= TOTAL + 1; t++) begin
      check_cycle(t, ovr_e);
      train_start = (t == inj_t) ? 1'b1 : 1'b0;
      if (t == inj_t && t >= CAPT && t < TOTAL) ovr_e = 1;
      @(negedge clk);
    end
    train_start = 1'b0;
  endtask

  initial begin
    int ovr_e;
    ovr_e       = 0;
    rst_n       = 1'b0;
    train_start = 1'b0;
    repeat (3) @(negedge clk);
    check_all_zero("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check_cycle(-1, 0);
      @(negedge clk);
    end
    check_all_zero("R1 idle after release");

    // strobe on the last capture cycle is ignored (R10)
    run_train(CAPT - 1, ovr_e);
    // strobe on the first readout cycle sets the flag (R9)
    run_train(CAPT, ovr_e);
    // flag stays set over a clean train (R9), back-to-back restart (R8)
    run_train(-1, ovr_e);
    // strobe mid-readout of a later row
    run_train(CAPT + RDT / 2 + 3, ovr_e);

    // asynchronous reset in mid-capture (R11)
    @(negedge clk);
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 capture running before reset", int'(pg_en), 1);
    #1 rst_n = 1'b0;
    #0.5;
    check_all_zero("R11 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all_zero("R11 idle after release");
    ovr_e = 0;
    run_train(2, ovr_e);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule